// File: doc/BRIEF.md
# SDRAM Initialization Command Sequencer

This block sits between a register-and-bus slave and the command pins of an SDRAM device. Software selects a command mode in a small mode register, then makes a dummy write access to any SDRAM address. The block turns each such access into exactly one SDRAM command: NOP with clock-enable start, precharge of all banks, auto-refresh, load of the standard or extended mode register, or deep power-down. For the mode-register loads, the access address carries the value to load. Its bank bits pick the standard register (both zero) or the extended register (any bank bit set).

The block enforces the power-up pause. After the clock-start NOP, any further command access is held with a wait signal until a cycle counter, derived from the clock frequency and the pause length in microseconds, has run out. The block keeps the clock-enable state. It counts auto-refresh commands so software can see when the required eight have gone out. It flags completion of deep power-down, so the controller can then safely be reset or have its clock stopped.

Top module: `sdram_init_seq`

## Requirements
- R1: The mode register resets to 0, is written from cfg_wdata_i when cfg_we_i is high, and mode_o shows the written value from the next cycle.
- R2: In mode 1 an access issues a NOP frame ({cs_n,ras_n,cas_n,we_n}=0111) and sets sd_cke_o high in that same cycle; it stays high afterwards.
- R3: In mode 2 an access issues precharge-all (0010) with address bit 10 high, all other address bits and the bank bits zero.
- R4: In mode 4 each access issues one auto-refresh (0001); ar_done_o goes high once 8 have been issued since the last mode-register write, and any mode-register write clears the count.
- R5: In mode 3 an access whose bank bits (top two address bits) are both zero issues load-mode (0000) with sd_a_o equal to the low address bits and sd_ba_o zero; with nonzero bank bits it raises acc_err_o and issues nothing.
- R6: In mode 5 an access with nonzero bank bits issues load-mode (0000) with sd_ba_o equal to the bank bits and sd_a_o equal to the low address bits; with both bank bits zero it raises acc_err_o and issues nothing.
- R7: After a NOP has been issued, accesses in modes 1 to 6 see acc_wait_o high and are not served until the pause count PAUSE_CYC has run out; a continuously requested command appears exactly PAUSE_CYC+1 cycles after the NOP.
- R8: In mode 6 an access issues a NOP frame with sd_cke_o going low in the same cycle and sets dpd_done_o; the next NOP access clears dpd_done_o.
- R9: In mode 0 accesses produce no command (pins stay 1111) and no acc_ready_o.
- R10: In mode 7 an access is answered with acc_ready_o, no error and no command.
- R11: Every served access gives acc_ready_o for exactly one cycle, the command frame lasts that one cycle, and a request still held in the ready cycle does not issue a second command.
- R12: After reset sd_cke_o is low, the command pins are 1111, acc_ready_o, acc_err_o, ar_done_o and dpd_done_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Mode register write strobe |
| cfg_wdata_i | input | 3 | Mode value to write |
| mode_o | output | 3 | Current mode register value |
| acc_req_i | input | 1 | Write access to SDRAM space, held until ready |
| acc_addr_i | input | A_W+BA_W | Access address; top BA_W bits are the bank |
| acc_wait_o | output | 1 | Access stalled by the power-up pause |
| acc_ready_o | output | 1 | Access served, one cycle |
| acc_err_o | output | 1 | Served access had an illegal bank for its mode |
| ar_done_o | output | 1 | Required auto-refresh count reached |
| dpd_done_o | output | 1 | Deep power-down issued |
| sd_cke_o | output | 1 | SDRAM clock enable |
| sd_cs_no | output | 1 | Chip select, active low |
| sd_ras_no | output | 1 | Row strobe, active low |
| sd_cas_no | output | 1 | Column strobe, active low |
| sd_we_no | output | 1 | Write enable, active low |
| sd_ba_o | output | BA_W | Bank address |
| sd_a_o | output | A_W | Address lines |

## Verification
The bench measures the gap between the clock-start NOP and the next command to the exact cycle. A timer that is off by one, or that does not stall at all, shows up as a wrong gap or a missing wait. It sweeps every bank value in both mode-load modes, so swapped bank rules fire a command where an error is due, or the other way round. It runs ten refreshes around a mode rewrite, so a counter that saturates early or ignores the clear reports done at the wrong count. It holds requests through the ready cycle, where a missing guard would put out a second command, and it checks that mode 0 and mode 7 leave the pins idle.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [2:0] {
    MODE_NORMAL = 3'd0,
    MODE_NOP    = 3'd1,
    MODE_PALL   = 3'd2,
    MODE_LMR    = 3'd3,
    MODE_AREF   = 3'd4,
    MODE_ELMR   = 3'd5,
    MODE_DPD    = 3'd6,
    MODE_RSVD   = 3'd7
  } mode_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } ctl_t;

  localparam ctl_t CTL_DESEL = 4'b1111;
  localparam ctl_t CTL_NOP   = 4'b0111;
  localparam ctl_t CTL_PALL  = 4'b0010;
  localparam ctl_t CTL_AREF  = 4'b0001;
  localparam ctl_t CTL_LMR   = 4'b0000;

  localparam int unsigned PALL_BIT = 10;

endpackage

// File: rtl/sdram_pause_timer.sv
module sdram_pause_timer #(
  parameter int unsigned CYC = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int unsigned LIM = (CYC < 1) ? 1 : CYC;
  localparam int unsigned CW  = $clog2(LIM + 1);
  localparam logic [CW-1:0] LOAD = CW'(LIM);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (start_i)       cnt_q <= LOAD;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/sdram_ref_counter.sv
module sdram_ref_counter #(
  parameter int unsigned NUM = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(NUM + 1);
  localparam logic [CW-1:0] TOP = CW'(NUM);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (clr_i)                 cnt_q <= '0;
    else if (inc_i && cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == TOP);
endmodule

// File: rtl/sdram_cmd_encoder.sv
module sdram_cmd_encoder
  import sdram_init_pkg::*;
#(
  parameter int unsigned A_W  = 13,
  parameter int unsigned BA_W = 2
) (
  input  logic [2:0]          mode_i,
  input  logic [A_W+BA_W-1:0] addr_i,
  output logic                issue_o,
  output logic                err_o,
  output ctl_t                ctl_o,
  output logic [BA_W-1:0]     ba_o,
  output logic [A_W-1:0]      a_o,
  output logic                cke_set_o,
  output logic                cke_clr_o,
  output logic                is_nop_o,
  output logic                is_aref_o,
  output logic                is_dpd_o
);
  logic [BA_W-1:0] bank;
  logic [A_W-1:0]  low;
  logic [A_W-1:0]  a_pall;

  assign bank = addr_i[A_W+BA_W-1 -: BA_W];
  assign low  = addr_i[A_W-1:0];

  always_comb begin
    a_pall           = '0;
    a_pall[PALL_BIT] = 1'b1;
  end

  always_comb begin
    issue_o   = 1'b0;
    err_o     = 1'b0;
    ctl_o     = CTL_DESEL;
    ba_o      = '0;
    a_o       = '0;
    cke_set_o = 1'b0;
    cke_clr_o = 1'b0;
    is_nop_o  = 1'b0;
    is_aref_o = 1'b0;
    is_dpd_o  = 1'b0;
    unique case (mode_e'(mode_i))
      MODE_NOP: begin
        issue_o   = 1'b1;
        ctl_o     = CTL_NOP;
        cke_set_o = 1'b1;
        is_nop_o  = 1'b1;
      end
      MODE_PALL: begin
        issue_o = 1'b1;
        ctl_o   = CTL_PALL;
        a_o     = a_pall;
      end
      MODE_AREF: begin
        issue_o   = 1'b1;
        ctl_o     = CTL_AREF;
        is_aref_o = 1'b1;
      end
      MODE_LMR: begin
        if (bank == '0) begin
          issue_o = 1'b1;
          ctl_o   = CTL_LMR;
          a_o     = low;
        end else begin
          err_o = 1'b1;
        end
      end
      MODE_ELMR: begin
        if (bank != '0) begin
          issue_o = 1'b1;
          ctl_o   = CTL_LMR;
          ba_o    = bank;
          a_o     = low;
        end else begin
          err_o = 1'b1;
        end
      end
      MODE_DPD: begin
        issue_o   = 1'b1;
        ctl_o     = CTL_NOP;
        cke_clr_o = 1'b1;
        is_dpd_o  = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int unsigned CLK_KHZ  = 133000,
  parameter int unsigned PAUSE_US = 200,
  parameter int unsigned A_W      = 13,
  parameter int unsigned BA_W     = 2,
  parameter int unsigned REF_NUM  = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic [2:0]          cfg_wdata_i,
  output logic [2:0]          mode_o,
  input  logic                acc_req_i,
  input  logic [A_W+BA_W-1:0] acc_addr_i,
  output logic                acc_wait_o,
  output logic                acc_ready_o,
  output logic                acc_err_o,
  output logic                ar_done_o,
  output logic                dpd_done_o,
  output logic                sd_cke_o,
  output logic                sd_cs_no,
  output logic                sd_ras_no,
  output logic                sd_cas_no,
  output logic                sd_we_no,
  output logic [BA_W-1:0]     sd_ba_o,
  output logic [A_W-1:0]      sd_a_o
);
  localparam int unsigned PAUSE_CYC = (CLK_KHZ / 1000) * PAUSE_US
                                    + ((CLK_KHZ % 1000) * PAUSE_US + 999) / 1000;

  logic [2:0]      mode_q;
  logic            rdy_q, err_q, cke_q, dpd_q;
  ctl_t            ctl_q;
  logic [BA_W-1:0] ba_q;
  logic [A_W-1:0]  a_q;

  logic            enc_issue, enc_err, enc_cke_set, enc_cke_clr;
  logic            enc_nop, enc_aref, enc_dpd;
  ctl_t            enc_ctl;
  logic [BA_W-1:0] enc_ba;
  logic [A_W-1:0]  enc_a;
  logic            pause_busy, needs_pause, accept;

  sdram_cmd_encoder #(.A_W(A_W), .BA_W(BA_W)) u_enc (
    .mode_i    (mode_q),
    .addr_i    (acc_addr_i),
    .issue_o   (enc_issue),
    .err_o     (enc_err),
    .ctl_o     (enc_ctl),
    .ba_o      (enc_ba),
    .a_o       (enc_a),
    .cke_set_o (enc_cke_set),
    .cke_clr_o (enc_cke_clr),
    .is_nop_o  (enc_nop),
    .is_aref_o (enc_aref),
    .is_dpd_o  (enc_dpd)
  );

  sdram_pause_timer #(.CYC(PAUSE_CYC)) u_pause (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (accept && enc_nop),
    .busy_o  (pause_busy)
  );

  sdram_ref_counter #(.NUM(REF_NUM)) u_ref (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cfg_we_i),
    .inc_i  (accept && enc_aref),
    .done_o (ar_done_o)
  );

  // modes 1..6 are pin-toggling modes and honour the pause
  assign needs_pause = (mode_q != MODE_NORMAL) && (mode_q != MODE_RSVD);
  assign acc_wait_o  = acc_req_i && needs_pause && pause_busy;
  assign accept      = acc_req_i && !rdy_q && (mode_q != MODE_NORMAL) && !acc_wait_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_NORMAL;
    else if (cfg_we_i) mode_q <= cfg_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q <= 1'b0;
      err_q <= 1'b0;
      ctl_q <= CTL_DESEL;
      ba_q  <= '0;
      a_q   <= '0;
    end else if (accept) begin
      rdy_q <= 1'b1;
      err_q <= enc_err;
      ctl_q <= enc_issue ? enc_ctl : CTL_DESEL;
      ba_q  <= enc_issue ? enc_ba  : '0;
      a_q   <= enc_issue ? enc_a   : '0;
    end else begin
      rdy_q <= 1'b0;
      err_q <= 1'b0;
      ctl_q <= CTL_DESEL;
      ba_q  <= '0;
      a_q   <= '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cke_q <= 1'b0;
      dpd_q <= 1'b0;
    end else if (accept) begin
      if (enc_cke_set)      cke_q <= 1'b1;
      else if (enc_cke_clr) cke_q <= 1'b0;
      if (enc_dpd)          dpd_q <= 1'b1;
      else if (enc_nop)     dpd_q <= 1'b0;
    end
  end

  assign mode_o      = mode_q;
  assign acc_ready_o = rdy_q;
  assign acc_err_o   = err_q;
  assign dpd_done_o  = dpd_q;
  assign sd_cke_o    = cke_q;
  assign sd_cs_no    = ctl_q.cs_n;
  assign sd_ras_no   = ctl_q.ras_n;
  assign sd_cas_no   = ctl_q.cas_n;
  assign sd_we_no    = ctl_q.we_n;
  assign sd_ba_o     = ba_q;
  assign sd_a_o      = a_q;
endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk #(
  parameter int unsigned A_W = 13
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           cfg_we_i,
  input logic [2:0]     cfg_wdata_i,
  input logic [2:0]     mode_o,
  input logic           acc_req_i,
  input logic           acc_wait_o,
  input logic           acc_ready_o,
  input logic           acc_err_o,
  input logic           dpd_done_o,
  input logic           sd_cke_o,
  input logic           sd_cs_no,
  input logic           sd_ras_no,
  input logic           sd_cas_no,
  input logic           sd_we_no,
  input logic [A_W-1:0] sd_a_o
);
  logic [3:0] ctl;
  assign ctl = {sd_cs_no, sd_ras_no, sd_cas_no, sd_we_no};

  p_mode_rb_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> mode_o == $past(cfg_wdata_i));

  p_cke_rise_nop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sd_cke_o) |-> (ctl == 4'b0111) && acc_ready_o);

  p_pall_a10_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl == 4'b0010) |-> sd_a_o[10]);

  p_err_no_cmd_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_err_o |-> sd_cs_no && acc_ready_o);

  p_wait_blocks_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_wait_o |=> !acc_ready_o);

  p_cke_fall_dpd_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sd_cke_o) |-> (ctl == 4'b0111) && dpd_done_o);

  p_normal_silent_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_req_i && mode_o == 3'd0) |=> !acc_ready_o);

  p_ready_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_ready_o |=> !acc_ready_o);

  p_cmd_with_ready_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sd_cs_no |-> acc_ready_o);
endmodule

bind sdram_init_seq sdram_init_seq_chk #(.A_W(A_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .cfg_wdata_i (cfg_wdata_i),
  .mode_o      (mode_o),
  .acc_req_i   (acc_req_i),
  .acc_wait_o  (acc_wait_o),
  .acc_ready_o (acc_ready_o),
  .acc_err_o   (acc_err_o),
  .dpd_done_o  (dpd_done_o),
  .sd_cke_o    (sd_cke_o),
  .sd_cs_no    (sd_cs_no),
  .sd_ras_no   (sd_ras_no),
  .sd_cas_no   (sd_cas_no),
  .sd_we_no    (sd_we_no),
  .sd_a_o      (sd_a_o)
);

// File: tb/sdram_init_seq_test.sv
`timescale 1ns/1ps
module sdram_init_seq_test;
  localparam int A_W = 13;
  localparam int BA_W = 2;
  localparam int P = 250;   // 250000 kHz * 1 us

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_wdata = '0;
  logic acc_req = 1'b0;
  logic [A_W+BA_W-1:0] acc_addr = '0;
  logic [2:0] mode;
  logic acc_wait, acc_ready, acc_err, ar_done, dpd_done;
  logic cke, cs_n, ras_n, cas_n, we_n;
  logic [BA_W-1:0] ba;
  logic [A_W-1:0] a;

  always #2 clk = ~clk;

  sdram_init_seq #(.CLK_KHZ(250000), .PAUSE_US(1), .A_W(A_W), .BA_W(BA_W), .REF_NUM(8)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata), .mode_o(mode),
    .acc_req_i(acc_req), .acc_addr_i(acc_addr), .acc_wait_o(acc_wait), .acc_ready_o(acc_ready),
    .acc_err_o(acc_err), .ar_done_o(ar_done), .dpd_done_o(dpd_done), .sd_cke_o(cke),
    .sd_cs_no(cs_n), .sd_ras_no(ras_n), .sd_cas_no(cas_n), .sd_we_no(we_n),
    .sd_ba_o(ba), .sd_a_o(a)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [3:0] r_ctl;
  logic r_cke, r_err, saw_wait;
  logic [BA_W-1:0] r_ba;
  logic [A_W-1:0] r_a;
  int t_rdy;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic set_mode(input logic [2:0] m);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = m;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic access(input logic [A_W+BA_W-1:0] addr);
    int n = 0;
    @(negedge clk); acc_req = 1'b1; acc_addr = addr; saw_wait = 1'b0;
    forever begin
      @(negedge clk);
      if (acc_wait) saw_wait = 1'b1;
      if (acc_ready) break;
      n++;
      if (n > 2000) begin
        chk(1'b0, "R11", "access never served", 0, 1);
        break;
      end
    end
    r_ctl = {cs_n, ras_n, cas_n, we_n};
    r_cke = cke; r_err = acc_err; r_ba = ba; r_a = a; t_rdy = cyc;
    acc_req = 1'b0;
    @(negedge clk);
    chk(!acc_ready && cs_n, "R11", "ready/cmd lasted past one cycle", {acc_ready, cs_n}, 1);
  endtask

  initial begin
    int t_nop;
    #1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(cke == 0, "R12", "cke", cke, 0);
    chk({cs_n, ras_n, cas_n, we_n} == 4'b1111, "R12", "pins", {cs_n, ras_n, cas_n, we_n}, 4'hf);
    chk(!acc_ready && !acc_err, "R12", "ready/err", {acc_ready, acc_err}, 0);
    chk(!ar_done && !dpd_done, "R12", "done flags", {ar_done, dpd_done}, 0);
    chk(mode == 0, "R1", "reset mode", mode, 0);

    // R9 normal mode: no command, no ready
    acc_req = 1'b1; acc_addr = 15'h1234;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(!acc_ready && {cs_n, ras_n, cas_n, we_n} == 4'hf, "R9", "normal mode activity",
          {acc_ready, cs_n, ras_n, cas_n, we_n}, 5'h0f);
    end
    acc_req = 1'b0;

    // R1 readback sweep
    for (int m = 0; m < 8; m++) begin
      set_mode(3'(m));
      chk(mode == 3'(m), "R1", "mode readback", mode, m);
    end

    // R10 reserved mode
    set_mode(3'd7);
    for (int k = 0; k < 4; k++) begin
      access(15'(k * 16'h1111));
      chk(r_ctl == 4'hf && !r_err, "R10", "reserved mode", {r_err, r_ctl}, 4'hf);
    end

    // R2 NOP, clock start
    set_mode(3'd1);
    access(15'h0);
    chk(r_ctl == 4'b0111, "R2", "nop frame", r_ctl, 4'b0111);
    chk(r_cke == 1, "R2", "cke with nop", r_cke, 1);
    t_nop = t_rdy;

    // R7 pause, R3 precharge
    set_mode(3'd2);
    access(15'h7fff);
    chk(saw_wait, "R7", "wait during pause", saw_wait, 1);
    chk(t_rdy - t_nop == P + 1, "R7", "nop to next command gap", t_rdy - t_nop, P + 1);
    chk(r_ctl == 4'b0010, "R3", "precharge frame", r_ctl, 4'b0010);
    chk(r_a == 13'h0400 && r_ba == 0, "R3", "precharge address", {r_ba, r_a}, 15'h0400);
    chk(cke == 1, "R2", "cke holds", cke, 1);

    // R4 auto-refresh counting
    set_mode(3'd4);
    for (int k = 1; k <= 10; k++) begin
      access(15'(k));
      chk(r_ctl == 4'b0001, "R4", "refresh frame", r_ctl, 4'b0001);
      chk(ar_done == (k >= 8), "R4", "refresh done flag", ar_done, k >= 8);
    end
    set_mode(3'd4);
    chk(ar_done == 0, "R4", "mode write clears count", ar_done, 0);
    for (int k = 1; k <= 8; k++) access(15'h0);
    chk(ar_done == 1, "R4", "done again after eight", ar_done, 1);

    // R5 standard mode-register load
    set_mode(3'd3);
    for (int b = 0; b < 4; b++) begin
      for (int p = 0; p < 3; p++) begin
        logic [A_W-1:0] lo;
        lo = (p == 0) ? 13'h0032 : (p == 1) ? 13'h1fff : 13'h0a5a;
        access({2'(b), lo});
        if (b == 0) begin
          chk(r_ctl == 4'b0000 && !r_err, "R5", "load frame", {r_err, r_ctl}, 0);
          chk(r_a == lo && r_ba == 0, "R5", "load address", {r_ba, r_a}, {2'b00, lo});
        end else begin
          chk(r_err && r_ctl == 4'hf, "R5", "bad bank rejected", {r_err, r_ctl}, 5'h1f);
        end
      end
    end

    // R6 extended mode-register load
    set_mode(3'd5);
    for (int b = 0; b < 4; b++) begin
      for (int p = 0; p < 2; p++) begin
        logic [A_W-1:0] lo;
        lo = (p == 0) ? 13'h0007 : 13'h1555;
        access({2'(b), lo});
        if (b != 0) begin
          chk(r_ctl == 4'b0000 && !r_err, "R6", "ext load frame", {r_err, r_ctl}, 0);
          chk(r_a == lo && r_ba == 2'(b), "R6", "ext load address", {r_ba, r_a}, {2'(b), lo});
        end else begin
          chk(r_err && r_ctl == 4'hf, "R6", "zero bank rejected", {r_err, r_ctl}, 5'h1f);
        end
      end
    end

    // R8 deep power-down
    set_mode(3'd6);
    access(15'h0);
    chk(r_ctl == 4'b0111 && r_cke == 0, "R8", "dpd frame and cke", {r_cke, r_ctl}, 5'h07);
    chk(dpd_done == 1, "R8", "dpd done set", dpd_done, 1);
    set_mode(3'd1);
    access(15'h0);
    chk(dpd_done == 0 && r_cke == 1, "R8", "nop clears dpd done", {dpd_done, r_cke}, 1);
    t_nop = t_rdy;
    set_mode(3'd4);
    access(15'h0);
    chk(saw_wait && t_rdy - t_nop == P + 1, "R7", "second pause", t_rdy - t_nop, P + 1);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    wait (cyc > 150000);
    if (!finished) begin
      finished = 1;
      chk(1'b0, "R11", "watchdog expired", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule